// File: doc/BRIEF.md
# Integer Logic and Arithmetic Unit

This block is the integer execution stage of a 32-bit big-endian RISC pipeline. Each cycle it takes an operation code, two register operands and a 16-bit immediate from instruction decode. One clock edge later it presents the 32-bit result on a register output. It covers additions with register, sign-extended or upper-halfword immediates. It also covers the full family of bitwise logic operations, including complement-operand and inverted forms and their immediate variants. The remaining operations are two's-complement negate, byte and halfword sign extension, logical and arithmetic shifts by a register or immediate amount, and count-leading-zeros.

Flags, carries, memory access and branching are handled elsewhere in the core. Operation codes the unit does not use produce zero, so a decoder fault shows as a clean zero result and never as stale data.

Top module: `int_exec_unit`

## Requirements
- R1: The result is registered. Inputs present at a rising clock edge appear on `result` after that edge. While `rst_n` is low, `result` is zero.
- R2: Code 0 returns a+b. Code 1 returns a plus the immediate sign-extended from bit 15. Code 2 returns a plus the immediate placed in bits 31..16 with zeros below. All three wrap modulo 2^32.
- R3: Code 3 returns a&b, code 5 returns a|b, and code 7 returns a^b.
- R4: Code 4 returns a & ~b, and code 6 returns a | ~b.
- R5: Code 8 returns ~(a&b), code 9 returns ~(a|b), and code 10 returns the bitwise XNOR ~(a^b).
- R6: Codes 11, 13 and 15 return a AND, OR and XOR the zero-extended immediate. Codes 12, 14 and 16 apply the immediate to bits 31..16 of a only.
- R7: Code 17 returns ~a + 1.
- R8: Code 18 copies a[7] into bits 31..8 above a[7:0]. Code 19 copies a[15] into bits 31..16 above a[15:0].
- R9: Codes 20, 21 and 22 shift a left, right logically and right arithmetically by b[5:0]. An amount from 32 to 63 gives zero for codes 20 and 21, and gives 32 copies of a[31] for code 22.
- R10: Codes 23, 24 and 25 perform the same three shifts by imm[4:0].
- R11: Code 26 returns the number of zero bits above the most significant one of a, and returns 32 when a is zero.
- R12: Codes 27 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation code |
| a | input | 32 | First register operand |
| b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field from the instruction |
| result | output | 32 | Registered result |

## Verification
The unit has exactly one register stage. Any decode, operand-selection or datapath error therefore shows on `result` in the cycle after the offending inputs, with no delay or masking. A wrong shifter stage corrupts only the amounts whose binary form includes that stage, which is why every amount from 0 to 63 is swept. A wrong fill bit shows only for negative operands or amounts of 32 and above. A fault in count-leading-zeros shows for a particular position of the highest set bit, so every single-bit position is applied along with zero.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 5;
    localparam int SHAMT_W = $clog2(XLEN) + 1;
    localparam int CNT_W  = $clog2(XLEN + 1);

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDI  = 5'd1,
        OP_ADDIS = 5'd2,
        OP_AND   = 5'd3,
        OP_ANDC  = 5'd4,
        OP_OR    = 5'd5,
        OP_ORC   = 5'd6,
        OP_XOR   = 5'd7,
        OP_NAND  = 5'd8,
        OP_NOR   = 5'd9,
        OP_EQV   = 5'd10,
        OP_ANDI  = 5'd11,
        OP_ANDIS = 5'd12,
        OP_ORI   = 5'd13,
        OP_ORIS  = 5'd14,
        OP_XORI  = 5'd15,
        OP_XORIS = 5'd16,
        OP_NEG   = 5'd17,
        OP_EXTB  = 5'd18,
        OP_EXTH  = 5'd19,
        OP_SLL   = 5'd20,
        OP_SRL   = 5'd21,
        OP_SRA   = 5'd22,
        OP_SLLI  = 5'd23,
        OP_SRLI  = 5'd24,
        OP_SRAI  = 5'd25,
        OP_CLZ   = 5'd26
    } exu_op_e;

    typedef enum logic [2:0] {
        LF_AND  = 3'd0,
        LF_ANDC = 3'd1,
        LF_OR   = 3'd2,
        LF_ORC  = 3'd3,
        LF_XOR  = 3'd4,
        LF_NAND = 3'd5,
        LF_NOR  = 3'd6,
        LF_EQV  = 3'd7
    } logic_fn_e;

    typedef enum logic [2:0] {
        RS_ZERO  = 3'd0,
        RS_ADD   = 3'd1,
        RS_LOGIC = 3'd2,
        RS_SHIFT = 3'd3,
        RS_CLZ   = 3'd4,
        RS_EXTB  = 3'd5,
        RS_EXTH  = 3'd6
    } res_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
    } exu_state_t;

endpackage

// File: rtl/iexu_add.sv
module iexu_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum
);

    assign sum = x + y + {{(W-1){1'b0}}, cin};

endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic_fn_e    fn,
    output logic [W-1:0] z
);

    logic [W-1:0] y_sel;
    logic [W-1:0] base;
    logic         inv_y;
    logic         inv_out;

    always_comb begin
        inv_y   = (fn == LF_ANDC) || (fn == LF_ORC);
        inv_out = (fn == LF_NAND) || (fn == LF_NOR) || (fn == LF_EQV);
        y_sel   = inv_y ? ~y : y;
        case (fn)
            LF_AND, LF_ANDC, LF_NAND: base = x & y_sel;
            LF_OR,  LF_ORC,  LF_NOR:  base = x | y_sel;
            default:                  base = x ^ y_sel;
        endcase
        z = inv_out ? ~base : base;
    end

endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
    parameter int W  = 32,
    parameter int AW = $clog2(W) + 1
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    localparam int STAGES = AW - 1;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = v[W-1-i];
        end
        return r;
    endfunction

    logic         fill;
    logic [W-1:0] pre;
    logic [W-1:0] stage [STAGES+1];
    logic [W-1:0] post;

    always_comb begin
        fill = arith & ~left & din[W-1];
        pre  = left ? flip(din) : din;
    end

    assign stage[0] = pre;

    // Each stage moves right by one power of two; left shifts run on the
    // reversed word so that a single right-moving network serves both.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = amt[s] ? {{SH{fill}}, stage[s][W-1:SH]} : stage[s];
        end
    endgenerate

    always_comb begin
        post = amt[AW-1] ? {W{fill}} : stage[STAGES];
        dout = left ? flip(post) : post;
    end

endmodule

// File: rtl/iexu_clz.sv
module iexu_clz #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] cnt
);

    // Scan upward; the highest set bit is the last to assign.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  result
);

    localparam int PAD_W = XLEN - IMM_W;

    exu_op_e          op_e;
    exu_state_t       state_d;
    exu_state_t       state_q;

    logic [XLEN-1:0]  imm_zx;
    logic [XLEN-1:0]  imm_sx;
    logic [XLEN-1:0]  imm_hi;

    logic [XLEN-1:0]  add_x;
    logic [XLEN-1:0]  add_y;
    logic             add_cin;
    logic [XLEN-1:0]  add_sum;

    logic [XLEN-1:0]  lg_y;
    logic_fn_e        lg_fn;
    logic [XLEN-1:0]  lg_z;

    logic [SHAMT_W-1:0] sh_amt;
    logic             sh_left;
    logic             sh_arith;
    logic [XLEN-1:0]  sh_out;

    logic [CNT_W-1:0] clz_cnt;
    res_sel_e         sel;

    // Decode: operand steering and unit controls
    always_comb begin
        op_e     = exu_op_e'(op);
        imm_zx   = {{PAD_W{1'b0}}, imm};
        imm_sx   = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_hi   = {imm, {PAD_W{1'b0}}};

        add_x    = a;
        add_y    = b;
        add_cin  = 1'b0;
        lg_y     = b;
        lg_fn    = LF_AND;
        sh_amt   = b[SHAMT_W-1:0];
        sh_left  = 1'b0;
        sh_arith = 1'b0;
        sel      = RS_ZERO;

        case (op_e)
            OP_ADD:   sel = RS_ADD;
            OP_ADDI:  begin sel = RS_ADD; add_y = imm_sx; end
            OP_ADDIS: begin sel = RS_ADD; add_y = imm_hi; end
            OP_NEG:   begin sel = RS_ADD; add_x = ~a; add_y = '0; add_cin = 1'b1; end
            OP_AND:   begin sel = RS_LOGIC; lg_fn = LF_AND;  end
            OP_ANDC:  begin sel = RS_LOGIC; lg_fn = LF_ANDC; end
            OP_OR:    begin sel = RS_LOGIC; lg_fn = LF_OR;   end
            OP_ORC:   begin sel = RS_LOGIC; lg_fn = LF_ORC;  end
            OP_XOR:   begin sel = RS_LOGIC; lg_fn = LF_XOR;  end
            OP_NAND:  begin sel = RS_LOGIC; lg_fn = LF_NAND; end
            OP_NOR:   begin sel = RS_LOGIC; lg_fn = LF_NOR;  end
            OP_EQV:   begin sel = RS_LOGIC; lg_fn = LF_EQV;  end
            OP_ANDI:  begin sel = RS_LOGIC; lg_fn = LF_AND; lg_y = imm_zx; end
            OP_ANDIS: begin sel = RS_LOGIC; lg_fn = LF_AND; lg_y = imm_hi; end
            OP_ORI:   begin sel = RS_LOGIC; lg_fn = LF_OR;  lg_y = imm_zx; end
            OP_ORIS:  begin sel = RS_LOGIC; lg_fn = LF_OR;  lg_y = imm_hi; end
            OP_XORI:  begin sel = RS_LOGIC; lg_fn = LF_XOR; lg_y = imm_zx; end
            OP_XORIS: begin sel = RS_LOGIC; lg_fn = LF_XOR; lg_y = imm_hi; end
            OP_EXTB:  sel = RS_EXTB;
            OP_EXTH:  sel = RS_EXTH;
            OP_SLL:   begin sel = RS_SHIFT; sh_left = 1'b1; end
            OP_SRL:   sel = RS_SHIFT;
            OP_SRA:   begin sel = RS_SHIFT; sh_arith = 1'b1; end
            OP_SLLI:  begin sel = RS_SHIFT; sh_left = 1'b1;
                            sh_amt = {1'b0, imm[SHAMT_W-2:0]}; end
            OP_SRLI:  begin sel = RS_SHIFT; sh_amt = {1'b0, imm[SHAMT_W-2:0]}; end
            OP_SRAI:  begin sel = RS_SHIFT; sh_arith = 1'b1;
                            sh_amt = {1'b0, imm[SHAMT_W-2:0]}; end
            OP_CLZ:   sel = RS_CLZ;
            default:  sel = RS_ZERO;
        endcase
    end

    iexu_add #(.W(XLEN)) u_add (
        .x   (add_x),
        .y   (add_y),
        .cin (add_cin),
        .sum (add_sum)
    );

    iexu_logic #(.W(XLEN)) u_logic (
        .x  (a),
        .y  (lg_y),
        .fn (lg_fn),
        .z  (lg_z)
    );

    iexu_shift #(.W(XLEN), .AW(SHAMT_W)) u_shift (
        .din   (a),
        .amt   (sh_amt),
        .left  (sh_left),
        .arith (sh_arith),
        .dout  (sh_out)
    );

    iexu_clz #(.W(XLEN), .CW(CNT_W)) u_clz (
        .din (a),
        .cnt (clz_cnt)
    );

    // Next-state: result selection
    always_comb begin
        state_d = '0;
        case (sel)
            RS_ADD:   state_d.result = add_sum;
            RS_LOGIC: state_d.result = lg_z;
            RS_SHIFT: state_d.result = sh_out;
            RS_CLZ:   state_d.result = {{(XLEN-CNT_W){1'b0}}, clz_cnt};
            RS_EXTB:  state_d.result = {{(XLEN-8){a[7]}}, a[7:0]};
            RS_EXTH:  state_d.result = {{PAD_W{a[IMM_W-1]}}, a[IMM_W-1:0]};
            default:  state_d.result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.result;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
    import iexu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op,
    input logic [XLEN-1:0]  a,
    input logic [XLEN-1:0]  b,
    input logic [IMM_W-1:0] imm,
    input logic [XLEN-1:0]  result
);

    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
        end
    end

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_ADD) |-> result == XLEN'($past(a) + $past(b)));

    // R4
    andc_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_ANDC) |-> (result & $past(b)) == '0);

    // R7
    neg_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_NEG) |-> XLEN'(result + $past(a)) == '0);

    // R8
    extb_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_EXTB) |-> result[XLEN-1:8] == {(XLEN-8){$past(a[7])}});

    // R9
    srl_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_SRL && $past(b[SHAMT_W-1])) |-> result == '0);

    // R11
    clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) == OP_CLZ && $past(a) == '0) |-> result == XLEN'(XLEN));

    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op) > OP_CLZ) |-> result == '0);

endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .a      (a),
    .b      (b),
    .imm    (imm),
    .result (result)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int_exec_unit dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .a      (a),
        .b      (b),
        .imm    (imm),
        .result (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(input logic [4:0] o);
        if (o <= 2) return "R2";
        if (o == 3 || o == 5 || o == 7) return "R3";
        if (o == 4 || o == 6) return "R4";
        if (o >= 8 && o <= 10) return "R5";
        if (o >= 11 && o <= 16) return "R6";
        if (o == 17) return "R7";
        if (o == 18 || o == 19) return "R8";
        if (o >= 20 && o <= 22) return "R9";
        if (o >= 23 && o <= 25) return "R10";
        if (o == 26) return "R11";
        return "R12";
    endfunction

    function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [15:0] k);
        logic [31:0] kz, ks, kh;
        int n;
        kz = {16'h0, k};
        ks = 32'($signed(k));
        kh = {k, 16'h0};
        case (o)
            5'd0:  return x + y;
            5'd1:  return x + ks;
            5'd2:  return x + kh;
            5'd3:  return x & y;
            5'd4:  return x & ~y;
            5'd5:  return x | y;
            5'd6:  return x | ~y;
            5'd7:  return x ^ y;
            5'd8:  return ~(x & y);
            5'd9:  return ~(x | y);
            5'd10: return ~(x ^ y);
            5'd11: return x & kz;
            5'd12: return x & kh;
            5'd13: return x | kz;
            5'd14: return x | kh;
            5'd15: return x ^ kz;
            5'd16: return x ^ kh;
            5'd17: return 32'd0 - x;
            5'd18: return 32'($signed(x[7:0]));
            5'd19: return 32'($signed(x[15:0]));
            5'd20: return x << y[5:0];
            5'd21: return x >> y[5:0];
            5'd22: return 32'($signed(x) >>> y[5:0]);
            5'd23: return x << k[4:0];
            5'd24: return x >> k[4:0];
            5'd25: return 32'($signed(x) >>> k[4:0]);
            5'd26: begin
                n = 0;
                while (n < 32 && x[31-n] == 1'b0) n++;
                return 32'(n);
            end
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic run(input logic [4:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [15:0] k);
        @(negedge clk);
        op = o; a = x; b = y; imm = k;
        @(negedge clk);
        check(tag_of(o), result, model(o, x, y, k));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [8];
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0080; corner[5] = 32'h0000_8000;
        corner[6] = 32'hA5A5_5A5A; corner[7] = 32'h0000_0001;

        // R1: reset state, with live inputs applied
        op = 5'd0; a = 32'h1234_5678; b = 32'h1111_1111;
        repeat (3) @(negedge clk);
        check("R1", result, 32'd0);
        rst_n = 1'b1;

        // R1: one-cycle latency, then a change of inputs is seen one cycle later
        @(negedge clk);
        op = 5'd7; a = 32'hF0F0_F0F0; b = 32'h0FF0_0FF0;
        @(negedge clk);
        check("R1", result, 32'hFF00_FF00);

        // Corner operands for every code, with several immediates
        for (int o = 0; o < 32; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    run(5'(o), corner[i], corner[j], corner[j][15:0] ^ 16'h8001);
                end
            end
        end

        // R9, R10: every shift amount, positive and negative operands
        for (int amt = 0; amt < 64; amt++) begin
            for (int s = 20; s <= 25; s++) begin
                run(5'(s), 32'h8765_4321, 32'(amt), 16'(amt) | 16'hFFC0);
                run(5'(s), 32'h1234_5678, 32'(amt) | 32'hFFFF_FFC0, 16'(amt));
            end
        end

        // R11: each single-bit position, ones below it, and zero
        for (int p = 0; p < 32; p++) begin
            run(5'd26, 32'd1 << p, 32'd0, 16'd0);
            run(5'd26, (32'd1 << p) | ((32'd1 << p) - 1), 32'd0, 16'd0);
        end
        run(5'd26, 32'd0, 32'd0, 16'd0);

        // R2, R6: immediate sign bit both ways
        run(5'd1, 32'h0000_0010, 32'd0, 16'hFFFF);
        run(5'd2, 32'hFFFF_0001, 32'd0, 16'h0002);
        run(5'd12, 32'hFFFF_FFFF, 32'd0, 16'h8001);

        // Random sweep over every code
        for (int n = 0; n < 200; n++) begin
            for (int o = 0; o < 32; o++) begin
                run(5'(o), $urandom, $urandom, 16'($urandom));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule